// File: doc/BRIEF.md
# USB Device Global Register and Interrupt Block

This block holds the shared, endpoint-independent registers of a five-endpoint USB device controller: the assigned device address, the power and suspend state, two interrupt status registers (one bit per endpoint, and three bus-event bits) with their enable masks, a 16-bit frame counter, and the endpoint selector used by the per-endpoint register banks. The endpoint units report events as single-cycle post pulses. The bus side reports events as strobes: a bus reset, a token seen, and a suspend detected. The block combines all of these into one registered, level-sensitive interrupt line.

Software uses a byte-wide port. A write is taken in the cycle that `reg_wr` is high. A read strobe returns data one cycle later, with `reg_rvalid` high for that cycle. The selector value drives two qualifier outputs, so the endpoint banks can tell whether their indexed registers are valid for the current selection.

Top module: `usbd_global_regs`

## Requirements
- R1: After reset, reads return the following values: address (offset 0) 0x00, power (1) 0x00, endpoint status (2) 0x00, bus status (3) 0x00, endpoint enable (4) 0x1F, bus enable (5) 0x04, frame low (6) 0x00, frame high (7) 0x00, and selector (8) 0x00. The `irq` output is low.
- R2: Writing to either status register (offset 2 or 3) clears every bit that is 1 in the written value and leaves every other bit unchanged. Once no status bit remains set, `irq` goes low one cycle later.
- R3: A write to the endpoint enable register keeps only bits 4:0. A write to the bus enable register keeps bits 0 and 2 and stores bit 1 as 1. A read of the bus enable register always shows bit 1 as 0.
- R4: A post is any nonzero `ep_post` or `bus_post`, or a `bus_reset`. In the cycle of a post, each posted bit is set in its status register. Both status registers are then ANDed with their current enables, and this applies to bits that were already set as well as new ones. `irq` is registered and is high in the cycle after any status bit remains set.
- R5: A write to the address register stores the value with bit 7 forced to 1. `dev_addr` becomes bits 6:0 of the written value.
- R6: A write to the power register takes bits 0 and 2 from the written value and keeps bits 1 and 3. If written bit 2 is 0, bit 1 is cleared. `suspend_seen` sets bit 1.
- R7: `bus_reset` sets power bit 3 and causes an interrupt re-mask as in R4. `token_seen` clears power bit 3. If both arrive in the same cycle, `bus_reset` wins.
- R8: Each `token_seen` pulse increments the 16-bit frame counter. The low byte reads at offset 6 and the high byte at offset 7, and the count carries from the low byte into the high byte.
- R9: The selector (offset 8) stores all 8 bits. `idx_valid` is high when the selector is below 5. `idx_full` is high when the selector is between 1 and 4, which are the endpoints that have their second IN register and their OUT registers.
- R10: A read of any offset from 9 to 15 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rvalid is high |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| ep_post | input | 5 | Endpoint interrupt post pulses, one bit per endpoint |
| bus_post | input | 3 | Bus-event interrupt post pulses |
| bus_reset | input | 1 | Bus reset seen |
| token_seen | input | 1 | SETUP, IN or OUT token seen |
| suspend_seen | input | 1 | Bus suspend detected |
| irq | output | 1 | Level interrupt request |
| dev_addr | output | 7 | Current device address |
| ep_index | output | 8 | Endpoint selector |
| idx_valid | output | 1 | Selector names an existing endpoint |
| idx_full | output | 1 | Selector names an endpoint with the full indexed register set |

## Verification
The bench checks that old status bits are re-masked on a post. If the new enable is applied only to the new bits, the already-set bit 4 survives. It also checks that a bus reset with no status bits posted still lowers `irq` after the enables are cleared; a design that re-masks only on endpoint posts would leave `irq` stuck high. For the power register, the bench writes with resume at 0 and at 1 while suspend is set, so a design that confuses the two cases either keeps a stale suspend bit or drops a live one. Other targets are the hidden bit 1 of the bus enable register, the frame carry from 0x00FF to 0x0100, and the selector edges at 0, 4 and 5.

// File: rtl/usbd_global_regs.sv
module usbd_global_regs #(
  parameter int NUM_EP = 5,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          reg_rvalid,
  input  logic [NUM_EP-1:0] ep_post,
  input  logic [2:0]    bus_post,
  input  logic          bus_reset,
  input  logic          token_seen,
  input  logic          suspend_seen,
  output logic          irq,
  output logic [6:0]    dev_addr,
  output logic [7:0]    ep_index,
  output logic          idx_valid,
  output logic          idx_full
);
  localparam logic [AW-1:0] O_ADDR = AW'(0), O_PWR = AW'(1), O_EPST = AW'(2),
                            O_BUSST = AW'(3), O_EPEN = AW'(4), O_BUSEN = AW'(5),
                            O_FRLO = AW'(6), O_FRHI = AW'(7), O_IDX = AW'(8);

  logic [7:0]        addr_q, idx_q;
  logic [3:0]        pwr_q, pwr_w, pwr_nxt;
  logic [NUM_EP-1:0] ep_st, ep_en, ep_nxt, ep_clr;
  logic [2:0]        bus_st, bus_en, bus_nxt, bus_clr;
  logic [15:0]       frame_q;
  logic              irq_q, post;

  wire wr_addr  = reg_wr && reg_addr == O_ADDR;
  wire wr_pwr   = reg_wr && reg_addr == O_PWR;
  wire wr_epst  = reg_wr && reg_addr == O_EPST;
  wire wr_busst = reg_wr && reg_addr == O_BUSST;
  wire wr_epen  = reg_wr && reg_addr == O_EPEN;
  wire wr_busen = reg_wr && reg_addr == O_BUSEN;
  wire wr_idx   = reg_wr && reg_addr == O_IDX;

  assign post    = (|ep_post) || (|bus_post) || bus_reset;
  assign ep_clr  = wr_epst  ? reg_wdata[NUM_EP-1:0] : '0;
  assign bus_clr = wr_busst ? reg_wdata[2:0] : '0;
  assign ep_nxt  = ((ep_st & ~ep_clr) | ep_post) & (post ? ep_en : '1);
  assign bus_nxt = ((bus_st & ~bus_clr) | bus_post) & (post ? bus_en : '1);

  assign pwr_w = wr_pwr ? {pwr_q[3], reg_wdata[2], pwr_q[1] & reg_wdata[2], reg_wdata[0]} : pwr_q;
  always_comb begin
    pwr_nxt = pwr_w;
    if (suspend_seen) pwr_nxt[1] = 1'b1;
    if (bus_reset)       pwr_nxt[3] = 1'b1;
    else if (token_seen) pwr_nxt[3] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q     <= '0;
      idx_q      <= '0;
      pwr_q      <= '0;
      ep_st      <= '0;
      bus_st     <= '0;
      ep_en      <= '1;
      bus_en     <= 3'b110;
      frame_q    <= '0;
      irq_q      <= 1'b0;
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      ep_st   <= ep_nxt;
      bus_st  <= bus_nxt;
      irq_q   <= (|ep_nxt) || (|bus_nxt);
      pwr_q   <= pwr_nxt;
      if (wr_addr)  addr_q <= reg_wdata | 8'h80;
      if (wr_idx)   idx_q  <= reg_wdata;
      if (wr_epen)  ep_en  <= reg_wdata[NUM_EP-1:0];
      if (wr_busen) bus_en <= {reg_wdata[2], 1'b1, reg_wdata[0]};
      if (token_seen) frame_q <= frame_q + 16'd1;
      reg_rvalid <= reg_rd;
      if (reg_rd) begin
        case (reg_addr)
          O_ADDR:  reg_rdata <= addr_q;
          O_PWR:   reg_rdata <= 8'(pwr_q);
          O_EPST:  reg_rdata <= 8'(ep_st);
          O_BUSST: reg_rdata <= 8'(bus_st);
          O_EPEN:  reg_rdata <= 8'(ep_en);
          O_BUSEN: reg_rdata <= 8'(bus_en & 3'b101);
          O_FRLO:  reg_rdata <= frame_q[7:0];
          O_FRHI:  reg_rdata <= frame_q[15:8];
          O_IDX:   reg_rdata <= idx_q;
          default: reg_rdata <= 8'h00;
        endcase
      end
    end
  end

  assign irq       = irq_q;
  assign dev_addr  = addr_q[6:0];
  assign ep_index  = idx_q;
  assign idx_valid = idx_q < 8'(NUM_EP);
  assign idx_full  = idx_valid && idx_q != 8'd0;

  a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_epst && reg_wdata == 8'hFF && ep_post == '0 |=> ep_st == '0);
  a_r3_busen_bit1_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == O_BUSEN |=> reg_rdata[1] == 1'b0);
  a_r4_irq_needs_post: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q ##1 irq_q |-> $past(post));
  a_r5_addr_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr |=> addr_q[7] && dev_addr == $past(reg_wdata[6:0]));
  a_r6_resume_low_drops_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pwr && !reg_wdata[2] && !suspend_seen |=> !pwr_q[1]);
  a_r7_reset_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> pwr_q[3]);
  a_r8_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    token_seen |=> frame_q == $past(frame_q) + 16'd1);
endmodule

// File: tb/sim_usbd_global_regs.sv
module sim_usbd_global_regs;
  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, ep_index;
  logic reg_rvalid, irq, idx_valid, idx_full;
  logic [4:0] ep_post = 0;
  logic [2:0] bus_post = 0;
  logic bus_reset = 0, token_seen = 0, suspend_seen = 0;
  logic [6:0] dev_addr;
  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  usbd_global_regs u0 (.clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
    .reg_rdata, .reg_rvalid, .ep_post, .bus_post, .bus_reset, .token_seen,
    .suspend_seen, .irq, .dev_addr, .ep_index, .idx_valid, .idx_full);

  always @(negedge clk) if (reg_rvalid) begin
    logic [7:0] e; string t;
    checks++;
    if (exp_q.size() == 0) begin fails++; $display("FAIL scoreboard: unexpected read data %02h, expected none", reg_rdata); end
    else begin
      e = exp_q.pop_front(); t = tag_q.pop_front();
      if (reg_rdata !== e) begin fails++; $display("FAIL %s: read %02h expected %02h", t, reg_rdata, e); end
    end
  end

  task automatic chk(string t, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin fails++; $display("FAIL %s: got %02h expected %02h", t, act, exp); end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk) reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk) reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] e, string t);
    @(negedge clk) reg_rd = 1; reg_addr = a; exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk) reg_rd = 0;
  endtask

  task automatic pulse_ep(logic [4:0] m);
    @(negedge clk) ep_post = m;
    @(negedge clk) ep_post = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    chk("R1 irq", 8'(irq), 8'h00);
    rd(0, 8'h00, "R1 addr"); rd(1, 8'h00, "R1 pwr"); rd(2, 8'h00, "R1 epst");
    rd(3, 8'h00, "R1 busst"); rd(4, 8'h1F, "R1 epen"); rd(5, 8'h04, "R1 busen");
    rd(6, 8'h00, "R1 frlo"); rd(7, 8'h00, "R1 frhi"); rd(8, 8'h00, "R1 idx");
    // R3 enable writes
    wr(4, 8'hFF); rd(4, 8'h1F, "R3 epen width");
    wr(5, 8'hFF); rd(5, 8'h05, "R3 busen bit1 hidden");
    wr(5, 8'h00); rd(5, 8'h00, "R3 busen zero");
    // R4 post and mask, R2 clear
    wr(4, 8'h05); pulse_ep(5'h03);
    chk("R4 irq after post", 8'(irq), 8'h01);
    rd(2, 8'h01, "R4 masked status");
    wr(2, 8'h01); chk("R2 irq after clear", 8'(irq), 8'h00);
    rd(2, 8'h00, "R2 epst cleared");
    @(negedge clk) bus_post = 3'h7; @(negedge clk) bus_post = 0;
    chk("R4 irq bus post", 8'(irq), 8'h01);
    rd(3, 8'h02, "R4 bus forced enable bit");
    wr(3, 8'h02); rd(3, 8'h00, "R2 busst cleared");
    chk("R2 irq low", 8'(irq), 8'h00);
    wr(4, 8'h1F); pulse_ep(5'h18); rd(2, 8'h18, "R4 two bits");
    wr(4, 8'h08); pulse_ep(5'h01); rd(2, 8'h08, "R4 old bits remasked");
    wr(2, 8'h08); rd(2, 8'h00, "R2 clear remaining");
    // R5 address
    wr(0, 8'h35); rd(0, 8'hB5, "R5 addr flag"); chk("R5 dev_addr", 8'(dev_addr), 8'h35);
    wr(0, 8'hFF); rd(0, 8'hFF, "R5 addr all"); chk("R5 dev_addr all", 8'(dev_addr), 8'h7F);
    // R6 power
    @(negedge clk) suspend_seen = 1; @(negedge clk) suspend_seen = 0;
    rd(1, 8'h02, "R6 suspend set");
    wr(1, 8'h05); rd(1, 8'h07, "R6 resume keeps suspend");
    wr(1, 8'h01); rd(1, 8'h01, "R6 resume low clears suspend");
    wr(1, 8'hFF); rd(1, 8'h05, "R6 only bits 0 and 2");
    wr(1, 8'h00); rd(1, 8'h00, "R6 cleared");
    // R7 bus reset and token
    wr(4, 8'h1F); pulse_ep(5'h02); chk("R7 irq pre", 8'(irq), 8'h01);
    wr(4, 8'h00); chk("R7 irq held without post", 8'(irq), 8'h01);
    @(negedge clk) bus_reset = 1; @(negedge clk) bus_reset = 0;
    chk("R7 reset remask irq", 8'(irq), 8'h00);
    rd(1, 8'h08, "R7 reset flag"); rd(2, 8'h00, "R7 status remasked");
    @(negedge clk) token_seen = 1; @(negedge clk) token_seen = 0;
    rd(1, 8'h00, "R7 token clears flag");
    // R8 frame counter carry
    rd(6, 8'h01, "R8 frame one");
    @(negedge clk) token_seen = 1;
    repeat (255) @(negedge clk);
    token_seen = 0;
    rd(6, 8'h00, "R8 frame low carry"); rd(7, 8'h01, "R8 frame high carry");
    // R9 selector
    wr(8, 8'h00); chk("R9 idx0 valid", 8'(idx_valid), 8'h01); chk("R9 idx0 full", 8'(idx_full), 8'h00);
    wr(8, 8'h04); chk("R9 idx4 valid", 8'(idx_valid), 8'h01); chk("R9 idx4 full", 8'(idx_full), 8'h01);
    wr(8, 8'h05); chk("R9 idx5 valid", 8'(idx_valid), 8'h00); chk("R9 idx5 full", 8'(idx_full), 8'h00);
    rd(8, 8'h05, "R9 idx read"); chk("R9 ep_index", ep_index, 8'h05);
    // R10 unmapped offsets
    for (int a = 9; a < 16; a++) rd(4'(a), 8'h00, "R10 unmapped");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin checks++; fails++; $display("FAIL scoreboard: %0d reads outstanding, expected 0", exp_q.size()); end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule